// File: doc/BRIEF.md
# Supply Bring-Up and Regulation Controller

This controller starts three switched-capacitor converter rails from a storage node and then keeps each rail in regulation. A request line arms a hysteretic check of the storage level. Once the storage level is reported good, the controller drives an active-low enable. It also starts a shared converter clock that paces a four-step switching sequence for every converter. The sequence is phase one, a dead step, phase two and a dead step.

Each converter switches only while its own droop comparator reports that the rail has sagged. An overvoltage report on the storage node forces every switching enable low. A rail counts as ready once its droop comparator has stayed quiet for a set number of cycles. The three ready flags are NANDed into an active-low acknowledge that answers the request. Dropping the request returns the controller to idle.

The comparator inputs are assumed to be synchronous to `clk`.

Top module: `supply_seq_ctrl`

## Requirements
- R1: While `req_i` is low, `en_n_o` stays high, `conv_clk_o` stays low and every switching enable stays low. From reset, `en_n_o` and `ack_n_o` are high, and `rdy_o`, `ph1_o`, `ph2_o` and `conv_clk_o` are zero.
- R2: With `req_i` high, the controller arms on the first clock edge. `en_n_o` goes low on the first edge where `stor_ok_i` is high and `stor_low_i` is low. It never goes low without a request.
- R3: While enabled, `stor_low_i` high at an edge drives `en_n_o` high at that edge. The converter clock then stops, low, one edge later. The controller stays armed and re-enables when `stor_ok_i` returns with `stor_low_i` low.
- R4: While enabled, `conv_clk_o` toggles once every `CLK_DIV` clock cycles.
- R5: A converter's `ph1_o` or `ph2_o` bit may be high only if, at the previous edge, all of these held: the controller was enabled, `req_i` was high, that rail's `droop_i` bit was 1 and `stor_ovp_i` was 0. With droop held, the rail repeats this sequence: `ph1` high for `CLK_DIV` cycles, both low for `CLK_DIV` cycles, `ph2` high for `CLK_DIV` cycles, both low for `CLK_DIV` cycles. `ph1` and `ph2` are never high together.
- R6: `stor_ovp_i` high at an edge forces every bit of `ph1_o` and `ph2_o` low after that edge.
- R7: Rail bit i of `rdy_o` sets after `RDY_CNT` consecutive enabled edges with `req_i` high and `droop_i[i]` = 0. A droop restarts the count but does not clear a flag already set. The flag clears on the first edge where `req_i` is low or the controller is not enabled.
- R8: `ack_n_o` is low exactly one cycle after all three `rdy_o` bits are 1, and high otherwise.
- R9: Dropping `req_i` returns the controller to idle at the next edge. All ready flags clear at that same edge, and `ack_n_o` is high one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Supply request |
| stor_ok_i | input | 1 | Storage above start threshold |
| stor_low_i | input | 1 | Storage below drop threshold |
| stor_ovp_i | input | 1 | Storage overvoltage report |
| droop_i | input | NRAIL | Per-rail droop comparator, 1 = below target |
| en_n_o | output | 1 | Active-low converter enable |
| conv_clk_o | output | 1 | Shared converter clock |
| ph1_o | output | NRAIL | Phase-one switching enable per rail |
| ph2_o | output | NRAIL | Phase-two switching enable per rail |
| rdy_o | output | NRAIL | Per-rail ready flag |
| ack_n_o | output | 1 | Active-low acknowledge |

## Verification
The assertions check the following on every cycle:
- the absence of an enable without a request;
- the drop-threshold shutdown;
- the idle clock;
- the exclusion and dead gap between phases;
- overvoltage and no-droop gating;
- flag clearing and the acknowledge relations.

Only the bench scenarios can show the exact latency from the start threshold to the enable. The same holds for the count of `RDY_CNT` quiet cycles before a flag sets and for the length of each phase step. Re-arming after a brown-out also needs a scenario. A cycle model in the bench checks the enable, ready and acknowledge outputs against random comparator activity.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  localparam int PH_STEPS  = 4;
  localparam int STEP_W    = 2;
  localparam logic [STEP_W-1:0] STEP_PH1 = 2'd0;
  localparam logic [STEP_W-1:0] STEP_PH2 = 2'd2;
endpackage

// File: rtl/supply_stor_monitor.sv
module supply_stor_monitor
  import supply_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic start_ok_i,
  input  logic drop_i,
  output logic run_o,
  output logic en_n_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_ARMED;
      ST_ARMED: begin
        if (!req_i) state_d = ST_IDLE;
        else if (start_ok_i && !drop_i) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!req_i) state_d = ST_IDLE;
        else if (drop_i) state_d = ST_ARMED;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      run_o   <= 1'b0;
      en_n_o  <= 1'b1;
    end else begin
      state_q <= state_d;
      run_o   <= (state_d == ST_RUN);
      en_n_o  <= (state_d != ST_RUN);
    end
  end

  p_no_req_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> en_n_o);
  p_start_needs_ok_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(en_n_o) |-> $past(start_ok_i && !drop_i && req_i));
  p_drop_stops_r3: assert property (@(posedge clk) disable iff (rst)
    drop_i |=> en_n_o);
endmodule

// File: rtl/supply_clk_gen.sv
module supply_clk_gen
  import supply_seq_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  output logic              conv_clk_o,
  output logic [STEP_W-1:0] step_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = run_i && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      div_q      <= '0;
      conv_clk_o <= 1'b0;
      step_o     <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        conv_clk_o <= ~conv_clk_o;
        step_o     <= step_o + 1'b1;
      end
    end
  end

  p_clk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !conv_clk_o);
endmodule

// File: rtl/supply_rail_reg.sv
module supply_rail_reg
  import supply_seq_pkg::*;
#(
  parameter int RDY_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              req_i,
  input  logic              ovp_i,
  input  logic              droop_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              rdy_o
);
  localparam int CNT_W = $clog2(RDY_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RDY_CNT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RDY_CNT - 1);

  logic             gate;
  logic [CNT_W-1:0] quiet_q;

  assign gate = run_i && req_i && droop_i && !ovp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph1_o <= 1'b0;
      ph2_o <= 1'b0;
    end else begin
      ph1_o <= gate && (step_i == STEP_PH1);
      ph2_o <= gate && (step_i == STEP_PH2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || !req_i) begin
      quiet_q <= '0;
      rdy_o   <= 1'b0;
    end else if (droop_i) begin
      quiet_q <= '0;
    end else if (quiet_q != CNT_FULL) begin
      quiet_q <= quiet_q + 1'b1;
      if (quiet_q == CNT_LAST) rdy_o <= 1'b1;
    end
  end

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(ph1_o && ph2_o));
  p_dead_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ph1_o) |-> !ph2_o);
  p_no_droop_off_r5: assert property (@(posedge clk) disable iff (rst)
    !droop_i |=> !ph1_o && !ph2_o);
  p_ovp_off_r6: assert property (@(posedge clk) disable iff (rst)
    ovp_i |=> !ph1_o && !ph2_o);
  p_rdy_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!req_i || !run_i) |=> !rdy_o);
endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import supply_seq_pkg::*;
#(
  parameter int NRAIL   = 3,
  parameter int CLK_DIV = 2,
  parameter int RDY_CNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             stor_ok_i,
  input  logic             stor_low_i,
  input  logic             stor_ovp_i,
  input  logic [NRAIL-1:0] droop_i,
  output logic             en_n_o,
  output logic             conv_clk_o,
  output logic [NRAIL-1:0] ph1_o,
  output logic [NRAIL-1:0] ph2_o,
  output logic [NRAIL-1:0] rdy_o,
  output logic             ack_n_o
);
  logic              run;
  logic [STEP_W-1:0] step;

  supply_stor_monitor u_mon (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .start_ok_i (stor_ok_i),
    .drop_i     (stor_low_i),
    .run_o      (run),
    .en_n_o     (en_n_o)
  );

  supply_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run),
    .conv_clk_o (conv_clk_o),
    .step_o     (step)
  );

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    supply_rail_reg #(.RDY_CNT(RDY_CNT)) u_rail (
      .clk     (clk),
      .rst     (rst),
      .run_i   (run),
      .req_i   (req_i),
      .ovp_i   (stor_ovp_i),
      .droop_i (droop_i[g]),
      .step_i  (step),
      .ph1_o   (ph1_o[g]),
      .ph2_o   (ph2_o[g]),
      .rdy_o   (rdy_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ack_n_o <= 1'b1;
    else     ack_n_o <= ~(&rdy_o);
  end

  p_ack_from_rdy_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n_o) |-> $past(&rdy_o));
  p_ack_release_r9: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ##1 ack_n_o);
endmodule

// File: tb/supply_seq_ctrl_tb.sv
module supply_seq_ctrl_tb;
  localparam int NR = 3;
  localparam int CD = 2;
  localparam int RC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, ok = 1'b0, low = 1'b0, ovp = 1'b0;
  logic [NR-1:0] droop = '0;
  logic en_n, cclk, ack_n;
  logic [NR-1:0] ph1, ph2, rdy;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // cycle model state
  int m_st = 0;
  int m_cnt [NR];
  logic [NR-1:0] m_rdy = '0;
  logic m_ackn = 1'b1;
  // inputs seen at the last edge
  logic p_run = 1'b0, p_req = 1'b0, p_ovp = 1'b0;
  logic [NR-1:0] p_droop = '0;

  always #4 clk = ~clk;

  supply_seq_ctrl #(.NRAIL(NR), .CLK_DIV(CD), .RDY_CNT(RC)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .stor_ok_i(ok), .stor_low_i(low),
    .stor_ovp_i(ovp), .droop_i(droop), .en_n_o(en_n), .conv_clk_o(cclk),
    .ph1_o(ph1), .ph2_o(ph2), .rdy_o(rdy), .ack_n_o(ack_n));

  task automatic chk(input bit ok_c, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok_c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NR-1:0] legal_mask();
    return (p_run && p_req && !p_ovp) ? p_droop : '0;
  endfunction

  task automatic model_compare();
    chk(en_n == (m_st != 2), "R2/R3 en_n model", en_n, m_st != 2);
    chk(rdy == m_rdy, "R7 rdy model", rdy, m_rdy);
    chk(ack_n == m_ackn, "R8 ack_n model", ack_n, m_ackn);
    chk(((ph1 | ph2) & ~legal_mask()) == '0, "R5/R6 switching legal",
        ph1 | ph2, legal_mask());
    chk((ph1 & ph2) == '0, "R5 no overlap", ph1 & ph2, 0);
  endtask

  task automatic model_step();
    logic run;
    logic [NR-1:0] r_old;
    run   = (m_st == 2);
    r_old = m_rdy;
    p_run = run; p_req = req; p_ovp = ovp; p_droop = droop;
    for (int i = 0; i < NR; i++) begin
      if (!run || !req) begin m_cnt[i] = 0; m_rdy[i] = 1'b0; end
      else if (droop[i]) m_cnt[i] = 0;
      else if (m_cnt[i] != RC) begin
        if (m_cnt[i] == RC - 1) m_rdy[i] = 1'b1;
        m_cnt[i]++;
      end
    end
    m_ackn = ~(&r_old);
    case (m_st)
      0: if (req) m_st = 1;
      1: if (!req) m_st = 0; else if (ok && !low) m_st = 2;
      default: if (!req) m_st = 0; else if (low) m_st = 1;
    endcase
  endtask

  // apply inputs, let one edge pass, compare at the following negedge
  task automatic cyc(input logic r, input logic o, input logic l,
                     input logic v, input logic [NR-1:0] d);
    req = r; ok = o; low = l; ovp = v; droop = d;
    model_step();
    @(negedge clk);
    model_compare();
  endtask

  initial begin
    int unsigned seed;
    int last_t, t, k, hi;
    logic prev_c;
    seed = $urandom(32'd2024);
    for (int i = 0; i < NR; i++) m_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state R1
    chk(en_n == 1'b1, "R1 reset en_n", en_n, 1);
    chk(ack_n == 1'b1, "R1 reset ack_n", ack_n, 1);
    chk(rdy == '0 && ph1 == '0 && ph2 == '0, "R1 reset flags", rdy | ph1 | ph2, 0);
    chk(cclk == 1'b0, "R1 reset conv_clk", cclk, 0);

    // R1: no request, storage good and droop reported
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, 0, 0, '1);
      chk(en_n && cclk == 0 && (ph1 | ph2) == '0, "R1 idle without request",
          {en_n, cclk, ph1, ph2}, 8'h80);
    end

    // R2: arm, then start threshold
    cyc(1, 0, 0, 0, '1);
    chk(en_n == 1'b1, "R2 armed but storage short", en_n, 1);
    cyc(1, 1, 0, 0, '1);
    chk(en_n == 1'b0, "R2 enable after start threshold", en_n, 0);

    // R4: clock period while enabled
    last_t = -1; t = 0; prev_c = cclk; k = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(1, 1, 0, 0, '1);
      t++;
      if (cclk != prev_c) begin
        if (last_t >= 0) begin
          chk(t - last_t == CD, "R4 conv_clk toggle period", t - last_t, CD);
          k++;
        end
        last_t = t;
      end
      prev_c = cclk;
    end
    chk(k >= 3, "R4 conv_clk running", k, 3);

    // R5: phase sequence on rail 0 with droop held
    k = 0;
    while (!(ph1[0] == 0) && k < 40) begin cyc(1, 1, 0, 0, '1); k++; end
    while (!(ph1[0] == 1) && k < 40) begin cyc(1, 1, 0, 0, '1); k++; end
    hi = 0;
    while (ph1[0] && hi < 20) begin hi++; cyc(1, 1, 0, 0, '1); end
    chk(hi == CD, "R5 ph1 width", hi, CD);
    hi = 0;
    while (!ph1[0] && !ph2[0] && hi < 20) begin hi++; cyc(1, 1, 0, 0, '1); end
    chk(hi == CD, "R5 dead gap before ph2", hi, CD);
    hi = 0;
    while (ph2[0] && hi < 20) begin hi++; cyc(1, 1, 0, 0, '1); end
    chk(hi == CD, "R5 ph2 width", hi, CD);

    // R7: ready after RC quiet cycles; R8 acknowledge
    for (int i = 1; i <= RC; i++) begin
      cyc(1, 1, 0, 0, '0);
      if (i == RC - 1) chk(rdy == '0, "R7 not ready early", rdy, 0);
    end
    chk(rdy == '1, "R7 ready after quiet count", rdy, 7);
    chk(ack_n == 1'b1, "R8 ack one cycle after ready", ack_n, 1);
    cyc(1, 1, 0, 0, '0);
    chk(ack_n == 1'b0, "R8 ack low when all ready", ack_n, 0);
    chk((ph1 | ph2) == '0, "R5 no switching without droop", ph1 | ph2, 0);

    // R7: droop keeps the flag
    cyc(1, 1, 0, 0, 3'b010);
    cyc(1, 1, 0, 0, 3'b010);
    chk(rdy == '1, "R7 droop keeps flag", rdy, 7);

    // R6: overvoltage blocks switching
    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, 0, 1, '1);
      chk((ph1 | ph2) == '0, "R6 overvoltage blocks switching", ph1 | ph2, 0);
    end

    // R3: drop threshold
    cyc(1, 0, 1, 0, '0);
    chk(en_n == 1'b1, "R3 enable released on drop", en_n, 1);
    cyc(1, 0, 0, 0, '0);
    chk(rdy == '0, "R7 flags clear after disable", rdy, 0);
    chk(cclk == 1'b0, "R3 conv_clk stopped", cclk, 0);
    cyc(1, 0, 0, 0, '0);
    chk(en_n == 1'b1, "R3 stays off until start threshold", en_n, 1);
    cyc(1, 1, 0, 0, '0);
    chk(en_n == 1'b0, "R3 re-enable from armed", en_n, 0);
    for (int i = 0; i < RC + 1; i++) cyc(1, 1, 0, 0, '0);
    chk(ack_n == 1'b0, "R8 ack after re-enable", ack_n, 0);

    // R9: request drop
    cyc(0, 1, 0, 0, '0);
    chk(en_n == 1'b1, "R9 idle after request drop", en_n, 1);
    chk(rdy == '0, "R9 flags cleared", rdy, 0);
    cyc(0, 1, 0, 0, '0);
    chk(ack_n == 1'b1, "R9 ack released", ack_n, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic r, o, l, v;
      logic [NR-1:0] d;
      r = ($urandom % 50) != 0;
      o = ($urandom % 4) != 0;
      l = ($urandom % 40) == 0;
      v = ($urandom % 30) == 0;
      d = (($urandom % 3) == 0) ? NR'($urandom) : '0;
      cyc(r, o, l, v, d);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule